// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

The block produces, one per clock, the column addresses of a single SDRAM burst. A start strobe loads a start column together with a burst-length code and a wrap-order bit. From the next cycle on, the block presents one column per cycle with a valid flag. It raises a last-beat flag on the final beat of a fixed-length burst. The order of the beats is either sequential or interleaved within the burst-aligned block. A full-page setting instead walks the whole 256-column row and wraps, and it runs until it is stopped.

A terminate strobe ends generation at once. A start strobe that arrives while a burst is running abandons that burst and begins again from the new column. This allows a fresh column command on every clock. The block only turns commands into addresses: it does no command decoding and moves no data.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high, and in the first output cycle after it, `valid_o` and `last_o` are 0.
- R2: When `start_i` is high at a rising edge, then after that edge `valid_o` is 1 and `col_o` equals the sampled `start_col_i`; each following edge advances by one beat.
- R3: Burst length comes from `bl_code_i`: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page; the codes 100, 101 and 110 give 1 beat.
- R4: With `interleave_i`=0 and a fixed length BL, beat i has the low log2(BL) bits of the start column plus i, modulo BL; the upper bits are kept from the start column.
- R5: With `interleave_i`=1 and a fixed length BL, beat i is the start column with its low log2(BL) bits XORed with i.
- R6: In full-page mode the column increases by one each beat, wraps from 255 to 0, and continues until a terminate or a new start; `interleave_i` is ignored and `last_o` stays 0.
- R7: `last_o` is 1 exactly on beat BL-1 of a fixed-length burst; on the edge after that beat, `valid_o` falls unless a new start is sampled.
- R8: `term_i` high at an edge, with `start_i` low, makes `valid_o` 0 after that edge; a terminate while idle has no visible effect.
- R9: `start_i` high during a running burst restarts from the new column, settings and beat 0; when `start_i` and `term_i` are both high, the start wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Column command strobe: load a new burst |
| start_col_i | input | 8 | Start column of the new burst |
| bl_code_i | input | 3 | Burst-length code (see R3) |
| interleave_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Burst terminate strobe |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | `col_o` carries a beat of a burst |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The hardest case to reach is the interplay of strobes at burst boundaries. Examples are a restart sampled on exactly the last beat, a start and a terminate in the same cycle, and a full-page run carried across the 255-to-0 wrap. The stimulus reaches these by driving one command per cycle from a cycle-accurate expectation model. Restarts are placed on chosen beat numbers. The full-page burst begins at column 253 with the interleave bit set, so that the wrap and the ignored order bit both fall within a few beats.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    parameter int unsigned COLW  = 8;
    parameter int unsigned BLC_W = 3;

    typedef enum logic [BLC_W-1:0] {
        BLC_1    = 3'b000,
        BLC_2    = 3'b001,
        BLC_4    = 3'b010,
        BLC_8    = 3'b011,
        BLC_PAGE = 3'b111
    } blcode_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        logic [COLW-1:0] mask;
        logic            full;
        order_e          order;
    } burst_cfg_t;

    typedef struct packed {
        logic            active;
        logic [COLW-1:0] base;
        logic [COLW-1:0] beat;
        burst_cfg_t      cfg;
    } burst_state_t;

    function automatic burst_cfg_t decode_cfg(logic [BLC_W-1:0] code, logic ilv);
        burst_cfg_t c;
        c.full  = 1'b0;
        c.order = ilv ? ORD_ILV : ORD_SEQ;
        c.mask  = '0;
        case (code)
            BLC_1, BLC_2, BLC_4, BLC_8:
                c.mask = COLW'((COLW'(1) << code[1:0]) - COLW'(1));
            BLC_PAGE: begin
                c.mask  = '1;
                c.full  = 1'b1;
                c.order = ORD_SEQ;
            end
            default: c.mask = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/colgen_cfg.sv
module colgen_cfg
    import colgen_pkg::*;
(
    input  logic [BLC_W-1:0] bl_code_i,
    input  logic             interleave_i,
    output burst_cfg_t       cfg_o
);

    always_comb begin
        cfg_o = decode_cfg(bl_code_i, interleave_i);
    end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import colgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [COLW-1:0] start_col_i,
    input  logic            term_i,
    input  burst_cfg_t      cfg_i,
    output burst_state_t    st_o,
    output logic            last_o
);

    burst_state_t st_q;
    burst_state_t st_d;
    logic         at_end;

    assign at_end = st_q.active && !st_q.cfg.full && (st_q.beat == st_q.cfg.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.beat   = '0;
            st_d.cfg    = cfg_i;
        end else if (term_i) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + COLW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o   = st_q;
    assign last_o = at_end;

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
    import colgen_pkg::*;
(
    input  burst_state_t    st_i,
    output logic [COLW-1:0] col_o
);

    logic [COLW-1:0] sum;

    assign sum = st_i.base + st_i.beat;

    for (genvar b = 0; b < COLW; b++) begin : g_bit
        always_comb begin
            if (!st_i.cfg.mask[b]) begin
                col_o[b] = st_i.base[b];
            end else if (st_i.cfg.order == ORD_ILV) begin
                col_o[b] = st_i.base[b] ^ st_i.beat[b];
            end else begin
                col_o[b] = sum[b];
            end
        end
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COLW-1:0]  start_col_i,
    input  logic [BLC_W-1:0] bl_code_i,
    input  logic             interleave_i,
    input  logic             term_i,
    output logic [COLW-1:0]  col_o,
    output logic             valid_o,
    output logic             last_o
);

    burst_cfg_t   cfg;
    burst_state_t st;

    colgen_cfg u_cfg (
        .bl_code_i    (bl_code_i),
        .interleave_i (interleave_i),
        .cfg_o        (cfg)
    );

    colgen_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .term_i      (term_i),
        .cfg_i       (cfg),
        .st_o        (st),
        .last_o      (last_o)
    );

    colgen_addr u_addr (
        .st_i  (st),
        .col_o (col_o)
    );

    assign valid_o = st.active;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o); // R7

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !valid_o); // R8

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid_o && st.cfg.full && !start_i && !term_i)
        |=> (valid_o && !last_o && col_o == COLW'($past(col_o) + COLW'(1)))); // R6

    AST_SEQ_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && st.cfg.order == ORD_SEQ && !start_i && !term_i)
        |=> ((col_o & ~st.cfg.mask) == ($past(col_o) & ~st.cfg.mask))); // R4

endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = 8'h00;
    logic [2:0] bl_code_i = 3'b000;
    logic       interleave_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_burst_colgen dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .interleave_i(interleave_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    typedef struct {
        int    due;
        bit    valid;
        bit    [7:0] col;
        bit    last;
        string req;
    } exp_t;

    exp_t q[$];

    // expectation model state
    bit       m_active = 0;
    bit [7:0] m_start;
    int       m_len;
    bit       m_full;
    bit       m_ilv;
    int       m_beat;

    function automatic int code_len(input bit [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic bit [7:0] exp_col(input bit [7:0] s, input int len, input bit full,
                                         input bit ilv, input int i);
        int base;
        if (full) return 8'((int'(s) + i) % 256);
        if (ilv) return s ^ 8'(i);
        base = int'(s) - (int'(s) % len);
        return 8'(base + ((int'(s) % len) + i) % len);
    endfunction

    task automatic step(input bit st, input bit [7:0] c, input bit [2:0] code,
                        input bit ilv, input bit tm, input string req);
        exp_t e;
        @(posedge clk);
        #2;
        start_i = st; start_col_i = c; bl_code_i = code;
        interleave_i = ilv; term_i = tm;
        if (st) begin
            m_active = 1; m_start = c; m_len = code_len(code);
            m_full = (code == 3'b111); m_ilv = ilv; m_beat = 0;
        end else if (tm) begin
            m_active = 0;
        end else if (m_active) begin
            if (!m_full && m_beat == m_len - 1) m_active = 0;
            else m_beat = (m_beat + 1) % 256;
        end
        e.due   = cyc + 1;
        e.valid = m_active;
        e.col   = exp_col(m_start, m_len, m_full, m_ilv, m_beat);
        e.last  = m_active && !m_full && (m_beat == m_len - 1);
        e.req   = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) step(0, 8'h00, 3'b000, 0, 0, req);
    endtask

    task automatic burst(input bit [7:0] c, input bit [2:0] code, input bit ilv,
                         input int beats, input string req);
        step(1, c, code, ilv, 0, req);
        for (int k = 1; k < beats; k++) step(0, 8'h00, 3'b000, 0, 0, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #4;
            while (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (valid_o !== e.valid || last_o !== e.last ||
                    (e.valid && col_o !== e.col)) begin
                    errors++;
                    $display("FAIL %s: got valid=%0b col=%02h last=%0b, expected valid=%0b col=%02h last=%0b",
                             e.req, valid_o, col_o, last_o, e.valid, e.col, e.last);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        checks++;
        if (valid_o !== 1'b0 || last_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%0b last=%0b, expected 0 0", valid_o, last_o);
        end
        @(posedge clk);
        #2;
        rst = 1'b0;
        idle(2, "R1");

        // sequential and interleaved orders
        burst(8'h0D, 3'b010, 0, 4, "R4");
        burst(8'h0D, 3'b010, 1, 4, "R5");
        burst(8'h35, 3'b011, 0, 8, "R4");
        burst(8'h35, 3'b011, 1, 8, "R5");
        burst(8'hA3, 3'b001, 0, 2, "R3");
        burst(8'hA3, 3'b001, 1, 2, "R3");
        idle(2, "R7");
        // lengths of one, including the unused codes
        burst(8'h7E, 3'b000, 0, 1, "R3");
        burst(8'h11, 3'b100, 0, 1, "R3");
        burst(8'h22, 3'b101, 1, 1, "R3");
        burst(8'h33, 3'b110, 0, 1, "R3");
        idle(2, "R7");
        // full page across the 255->0 wrap, order bit set but ignored
        burst(8'hFD, 3'b111, 1, 300, "R6");
        step(0, 8'h00, 3'b000, 0, 1, "R8");
        idle(2, "R8");
        // terminate in the middle of an 8-beat burst
        burst(8'h48, 3'b011, 0, 3, "R8");
        step(0, 8'h00, 3'b000, 0, 1, "R8");
        idle(1, "R8");
        // terminate while idle
        step(0, 8'h00, 3'b000, 0, 1, "R8");
        idle(1, "R8");
        // restart mid burst, restart on last beat, start wins over terminate
        burst(8'h60, 3'b011, 1, 3, "R9");
        burst(8'h92, 3'b010, 0, 4, "R9");
        burst(8'hC5, 3'b001, 1, 2, "R9");
        step(1, 8'h17, 3'b010, 0, 1, "R9");
        idle(5, "R2");
        burst(8'hEE, 3'b111, 0, 3, "R2");
        burst(8'h05, 3'b011, 0, 9, "R7");
        idle(3, "R7");

        repeat (3) @(posedge clk);
        #5;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule